// File: doc/BRIEF.md
# Synonym-Detecting Inclusive L2 Tag Controller

This block holds the tags and control state of a direct-mapped, physically indexed and physically tagged second-level cache. That cache includes every line of a 2-way, 32 KB first-level data cache with 16-byte blocks. The first level is indexed by 10 bits. Page offsets are 12 bits, so the two most significant of those index bits are the low two virtual page number bits. A single physical line can therefore sit in any of four first-level sets, depending on which virtual alias brought it in.

To catch such synonyms, each second-level entry stores, beside its physical tag, the two virtual index bits of the access that allocated it. Both take part in the compare. A first-level miss request carries the physical address, its two virtual index bits, the first-level way chosen for the fill, and a write flag. One cycle later the block answers hit or miss. An access that reaches the same physical line through a different alias fails the compare and is handled like a conflict miss. Whenever a valid line is displaced, the block issues a back-invalidate naming the first-level set, the way and the line address of the old copy. It raises a writeback strobe if the old line was dirty, and allocates the new line in the same cycle. Data arrays and the refill path are outside this block.

Top module: `l2syn_tags`

## Requirements
- R1: After reset every entry is invalid, and rsp_valid, bi_valid and wb_valid are low until a request arrives.
- R2: Each cycle with req_valid high produces rsp_valid high in the following cycle; rsp_valid is low after a cycle without a request; requests may come back to back.
- R3: rsp_hit is 1 exactly when the entry selected by req_paddr[4 +: L2_IDX_W] is valid and both its stored physical tag (req_paddr bits above the index) and its stored virtual index bits equal those of the request.
- R4: If the entry is valid with an equal physical tag but different virtual index bits, the response is a miss with rsp_alias = 1 and a back-invalidate of the old copy.
- R5: If the entry is valid with a different physical tag, the response is a miss with rsp_alias = 0 and a back-invalidate of the old line.
- R6: A back-invalidate reports bi_set = {stored virtual index bits, old line address bits [11:4]}, bi_way = the first-level way recorded for the old line, and bi_paddr = the old line address with bits [3:0] zero.
- R7: wb_valid is high, with wb_paddr equal to bi_paddr, exactly when the displaced line is dirty; it appears in the same cycle as the back-invalidate.
- R8: Every miss allocates the entry with the request's tag, virtual index bits and way, and marks it dirty exactly when req_write is 1; an immediate repeat of the same request hits.
- R9: A hit raises neither back-invalidate nor writeback, records the request's way, and leaves the line dirty if it was dirty or req_write is 1.
- R10: A miss on an invalid entry raises neither back-invalidate nor writeback.
- R11: When a first-level cache fills each missed line into set {virtual index bits, paddr[11:4]} and obeys every back-invalidate, no physical line is ever held in two different first-level sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | First-level miss request present |
| req_paddr | input | PA_W | Physical address of the request |
| req_vpn_lo | input | 2 | Low two virtual page number bits of the request |
| req_way | input | $clog2(L1_WAYS) | First-level way that will receive the fill |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Line present with matching tag and virtual bits |
| rsp_alias | output | 1 | Miss caused by a virtual alias of a resident line |
| bi_valid | output | 1 | Back-invalidate to the first level |
| bi_set | output | 10 | First-level set to invalidate |
| bi_way | output | $clog2(L1_WAYS) | First-level way to invalidate |
| bi_paddr | output | PA_W | Line address being invalidated |
| wb_valid | output | 1 | Displaced line is dirty and must be written back |
| wb_paddr | output | PA_W | Line address to write back |

## Verification
The bound checker watches, on every cycle, the response timing, that a hit never comes with an eviction, that an alias miss invalidates the same physical line under different virtual bits, that a writeback only travels with a back-invalidate of the same line, and that a repeated request hits. Properties over the response alone cannot show the remembered way after a later hit, dirty state that builds up over several hits, or the absence of duplicate copies across first-level sets. Those need the bench's reference model and its model of the first-level cache, driven by the design's own back-invalidates.

// File: rtl/l2syn_pkg.sv
package l2syn_pkg;
  // first-level geometry fixed by the page and block sizes
  localparam int BLK_OFF_W = 4;
  localparam int PG_OFF_W  = 12;
  localparam int VLO_W     = 2;
  localparam int L1_SET_W  = VLO_W + PG_OFF_W - BLK_OFF_W;

  typedef enum logic [1:0] {
    LK_FILL     = 2'd0,
    LK_HIT      = 2'd1,
    LK_ALIAS    = 2'd2,
    LK_CONFLICT = 2'd3
  } lk_kind_e;
endpackage

// File: rtl/l2syn_tag_store.sv
module l2syn_tag_store
  import l2syn_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int TAG_W = 19,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [VLO_W-1:0] rd_vlo,
  output logic [WAY_W-1:0] rd_way,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [VLO_W-1:0] wr_vlo,
  input  logic [WAY_W-1:0] wr_way,
  input  logic             wr_dirty
);
  localparam int DEPTH = 1 << IDX_W;

  logic             valid_arr [DEPTH];
  logic [TAG_W-1:0] tag_arr   [DEPTH];
  logic [VLO_W-1:0] vlo_arr   [DEPTH];
  logic [WAY_W-1:0] way_arr   [DEPTH];
  logic             dirty_arr [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             sel;
    logic             v_q;
    logic [TAG_W-1:0] tag_q;
    logic [VLO_W-1:0] vlo_q;
    logic [WAY_W-1:0] way_q;
    logic             dirty_q;

    assign sel = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q <= 1'b1;
      end
    end

    // payload is only meaningful while v_q is set
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q   <= wr_tag;
        vlo_q   <= wr_vlo;
        way_q   <= wr_way;
        dirty_q <= wr_dirty;
      end
    end

    assign valid_arr[e] = v_q;
    assign tag_arr[e]   = tag_q;
    assign vlo_arr[e]   = vlo_q;
    assign way_arr[e]   = way_q;
    assign dirty_arr[e] = dirty_q;
  end

  assign rd_valid = valid_arr[rd_idx];
  assign rd_tag   = tag_arr[rd_idx];
  assign rd_vlo   = vlo_arr[rd_idx];
  assign rd_way   = way_arr[rd_idx];
  assign rd_dirty = dirty_arr[rd_idx];
endmodule

// File: rtl/l2syn_lookup.sv
module l2syn_lookup
  import l2syn_pkg::*;
#(
  parameter int TAG_W = 19
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [VLO_W-1:0] ent_vlo,
  input  logic             ent_dirty,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [VLO_W-1:0] req_vlo,
  input  logic             req_write,
  output lk_kind_e         kind,
  output logic             evict,
  output logic             wb,
  output logic             new_dirty
);
  logic tag_eq;
  logic vlo_eq;

  always_comb begin
    tag_eq = (ent_tag == req_tag);
    vlo_eq = (ent_vlo == req_vlo);
    if (!ent_valid) begin
      kind = LK_FILL;
    end else if (tag_eq && vlo_eq) begin
      kind = LK_HIT;
    end else if (tag_eq) begin
      kind = LK_ALIAS;
    end else begin
      kind = LK_CONFLICT;
    end

    unique case (kind)
      LK_ALIAS, LK_CONFLICT: evict = 1'b1;
      default:               evict = 1'b0;
    endcase

    wb        = evict && ent_dirty;
    new_dirty = (kind == LK_HIT) ? (ent_dirty | req_write) : req_write;
  end
endmodule

// File: rtl/l2syn_bi_fmt.sv
module l2syn_bi_fmt
  import l2syn_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int IDX_W = 9,
  parameter int TAG_W = 19
) (
  input  logic [TAG_W-1:0]    ent_tag,
  input  logic [VLO_W-1:0]    ent_vlo,
  input  logic [IDX_W-1:0]    idx,
  output logic [L1_SET_W-1:0] l1_set,
  output logic [PA_W-1:0]     line_pa
);
  // rebuild the old line address, then the first-level set it was filled into
  assign line_pa = {ent_tag, idx, {BLK_OFF_W{1'b0}}};
  assign l1_set  = {ent_vlo, line_pa[PG_OFF_W-1:BLK_OFF_W]};
endmodule

// File: rtl/l2syn_tags.sv
module l2syn_tags
  import l2syn_pkg::*;
#(
  parameter int PA_W     = 32,
  parameter int L2_IDX_W = 9,
  parameter int L1_WAYS  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [PA_W-1:0]            req_paddr,
  input  logic [VLO_W-1:0]           req_vpn_lo,
  input  logic [$clog2(L1_WAYS)-1:0] req_way,
  input  logic                       req_write,
  output logic                       rsp_valid,
  output logic                       rsp_hit,
  output logic                       rsp_alias,
  output logic                       bi_valid,
  output logic [L1_SET_W-1:0]        bi_set,
  output logic [$clog2(L1_WAYS)-1:0] bi_way,
  output logic [PA_W-1:0]            bi_paddr,
  output logic                       wb_valid,
  output logic [PA_W-1:0]            wb_paddr
);
  localparam int WAY_W = $clog2(L1_WAYS);
  localparam int TAG_W = PA_W - BLK_OFF_W - L2_IDX_W;

  logic [L2_IDX_W-1:0] req_idx;
  logic [TAG_W-1:0]    req_tag;
  logic                unused_offset;

  logic                ent_valid;
  logic [TAG_W-1:0]    ent_tag;
  logic [VLO_W-1:0]    ent_vlo;
  logic [WAY_W-1:0]    ent_way;
  logic                ent_dirty;

  lk_kind_e            kind;
  logic                evict;
  logic                wb;
  logic                new_dirty;
  logic [L1_SET_W-1:0] old_set;
  logic [PA_W-1:0]     old_line;

  logic                rsp_valid_d;
  logic                rsp_hit_d;
  logic                rsp_alias_d;
  logic                bi_valid_d;
  logic                wb_valid_d;
  logic                fld_en;

  assign req_idx       = req_paddr[BLK_OFF_W +: L2_IDX_W];
  assign req_tag       = req_paddr[PA_W-1 -: TAG_W];
  assign unused_offset = ^req_paddr[BLK_OFF_W-1:0];

  l2syn_tag_store #(
    .IDX_W (L2_IDX_W),
    .TAG_W (TAG_W),
    .WAY_W (WAY_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_valid (ent_valid),
    .rd_tag   (ent_tag),
    .rd_vlo   (ent_vlo),
    .rd_way   (ent_way),
    .rd_dirty (ent_dirty),
    .wr_en    (req_valid),
    .wr_idx   (req_idx),
    .wr_tag   (req_tag),
    .wr_vlo   (req_vpn_lo),
    .wr_way   (req_way),
    .wr_dirty (new_dirty)
  );

  l2syn_lookup #(
    .TAG_W (TAG_W)
  ) u_lookup (
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .ent_vlo   (ent_vlo),
    .ent_dirty (ent_dirty),
    .req_tag   (req_tag),
    .req_vlo   (req_vpn_lo),
    .req_write (req_write),
    .kind      (kind),
    .evict     (evict),
    .wb        (wb),
    .new_dirty (new_dirty)
  );

  l2syn_bi_fmt #(
    .PA_W  (PA_W),
    .IDX_W (L2_IDX_W),
    .TAG_W (TAG_W)
  ) u_fmt (
    .ent_tag (ent_tag),
    .ent_vlo (ent_vlo),
    .idx     (req_idx),
    .l1_set  (old_set),
    .line_pa (old_line)
  );

  // next-state
  always_comb begin
    rsp_valid_d = req_valid;
    rsp_hit_d   = req_valid && (kind == LK_HIT);
    rsp_alias_d = req_valid && (kind == LK_ALIAS);
    bi_valid_d  = req_valid && evict;
    wb_valid_d  = req_valid && wb;
    fld_en      = req_valid && evict;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_alias <= 1'b0;
      bi_valid  <= 1'b0;
      wb_valid  <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_alias <= rsp_alias_d;
      bi_valid  <= bi_valid_d;
      wb_valid  <= wb_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bi_set   <= '0;
      bi_way   <= '0;
      bi_paddr <= '0;
      wb_paddr <= '0;
    end else if (fld_en) begin
      bi_set   <= old_set;
      bi_way   <= ent_way;
      bi_paddr <= old_line;
      wb_paddr <= old_line;
    end
  end
endmodule

// File: rtl/l2syn_checker.sv
module l2syn_checker
  import l2syn_pkg::*;
#(
  parameter int PA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [PA_W-1:0]     req_paddr,
  input logic [VLO_W-1:0]    req_vpn_lo,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic                rsp_alias,
  input logic                bi_valid,
  input logic [L1_SET_W-1:0] bi_set,
  input logic [PA_W-1:0]     bi_paddr,
  input logic                wb_valid,
  input logic [PA_W-1:0]     wb_paddr
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_hit_is_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_valid && !bi_valid && !wb_valid && !rsp_alias));

  assert_alias_evicts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_alias |-> (bi_valid && !rsp_hit));

  assert_evict_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bi_valid |-> (rsp_valid && !rsp_hit));

  assert_wb_same_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (bi_valid && (wb_paddr == bi_paddr)));

  assert_bi_set_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bi_valid |-> (bi_set[L1_SET_W-VLO_W-1:0] == bi_paddr[PG_OFF_W-1:BLK_OFF_W]));

  assert_alias_same_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_alias ||
      ((bi_paddr[PA_W-1:BLK_OFF_W] == $past(req_paddr[PA_W-1:BLK_OFF_W])) &&
       (bi_set[L1_SET_W-1 -: VLO_W] != $past(req_vpn_lo)))));

  assert_repeat_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid) &&
     (req_paddr[PA_W-1:BLK_OFF_W] == $past(req_paddr[PA_W-1:BLK_OFF_W])) &&
     (req_vpn_lo == $past(req_vpn_lo))) |=> rsp_hit);
endmodule

bind l2syn_tags l2syn_checker #(.PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_paddr  (req_paddr),
  .req_vpn_lo (req_vpn_lo),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_alias  (rsp_alias),
  .bi_valid   (bi_valid),
  .bi_set     (bi_set),
  .bi_paddr   (bi_paddr),
  .wb_valid   (wb_valid),
  .wb_paddr   (wb_paddr)
);

// File: tb/l2syn_tags_tb_top.sv
module l2syn_tags_tb_top;
  localparam int PA_W = 32;
  localparam int IDXW = 9;
  localparam int WAYS = 2;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_paddr;
  logic [1:0]  req_vpn_lo;
  logic [0:0]  req_way;
  logic        req_write;
  logic        rsp_valid;
  logic        rsp_hit;
  logic        rsp_alias;
  logic        bi_valid;
  logic [9:0]  bi_set;
  logic [0:0]  bi_way;
  logic [31:0] bi_paddr;
  logic        wb_valid;
  logic [31:0] wb_paddr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model of the tag array, keyed by index
  bit          m_v     [int];
  int unsigned m_tag   [int];
  int          m_vlo   [int];
  int          m_way   [int];
  bit          m_dirty [int];
  // first-level model: key = set*2+way, value = line address
  int unsigned l1_line [int];

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  l2syn_tags #(.PA_W(PA_W), .L2_IDX_W(IDXW), .L1_WAYS(WAYS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_paddr(req_paddr), .req_vpn_lo(req_vpn_lo),
    .req_way(req_way), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_alias(rsp_alias),
    .bi_valid(bi_valid), .bi_set(bi_set), .bi_way(bi_way), .bi_paddr(bi_paddr),
    .wb_valid(wb_valid), .wb_paddr(wb_paddr)
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic bit l1_holds(input int unsigned pa, input int vlo);
    int s;
    int unsigned ln;
    s  = (vlo << 8) | ((pa >> 4) & 255);
    ln = pa & ~32'hF;
    for (int w = 0; w < 2; w++) begin
      if (l1_line.exists(s*2+w) && l1_line[s*2+w] == ln) return 1;
    end
    return 0;
  endfunction

  task automatic check_no_dup();
    int  seen [int unsigned];
    bit  bad;
    bad = 0;
    foreach (l1_line[k]) begin
      if (seen.exists(l1_line[k]) && seen[l1_line[k]] != k/2) bad = 1;
      seen[l1_line[k]] = k/2;
    end
    chk("R11", "line held in two L1 sets", longint'(bad), 0);
  endtask

  task automatic issue(input int unsigned pa, input int vlo, input int way, input bit wr);
    int          idx;
    int unsigned tg;
    bit          e_hit, e_alias, e_bi, e_wb;
    int          e_set, e_way;
    int unsigned e_line;
    int          fkey;
    idx = (pa >> 4) & ((1 << IDXW) - 1);
    tg  = pa >> (4 + IDXW);
    e_hit = 0; e_alias = 0; e_bi = 0; e_wb = 0; e_set = 0; e_way = 0; e_line = 0;
    if (m_v.exists(idx) && m_v[idx]) begin
      if (m_tag[idx] == tg && m_vlo[idx] == vlo) begin
        e_hit = 1;
      end else begin
        e_alias = (m_tag[idx] == tg);
        e_bi    = 1;
        e_wb    = m_dirty[idx];
        e_line  = (m_tag[idx] << (4 + IDXW)) | (idx << 4);
        e_set   = (m_vlo[idx] << 8) | ((e_line >> 4) & 255);
        e_way   = m_way[idx];
      end
    end
    if (e_hit) begin
      m_way[idx]   = way;
      m_dirty[idx] = m_dirty[idx] | wr;
    end else begin
      m_v[idx] = 1; m_tag[idx] = tg; m_vlo[idx] = vlo; m_way[idx] = way; m_dirty[idx] = wr;
    end

    @(negedge clk);
    // idle cycle before this request: nothing may be reported
    chk("R2", "rsp_valid idle", longint'(rsp_valid), 0);
    chk("R5", "bi_valid idle", longint'(bi_valid), 0);
    chk("R7", "wb_valid idle", longint'(wb_valid), 0);
    req_valid  = 1'b1;
    req_paddr  = pa;
    req_vpn_lo = 2'(vlo);
    req_way    = 1'(way);
    req_write  = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "rsp_valid", longint'(rsp_valid), 1);
    chk("R3", "rsp_hit", longint'(rsp_hit), longint'(e_hit));
    chk("R4", "rsp_alias", longint'(rsp_alias), longint'(e_alias));
    chk("R5", "bi_valid", longint'(bi_valid), longint'(e_bi));
    if (e_bi) begin
      chk("R6", "bi_set", longint'(bi_set), longint'(e_set));
      chk("R6", "bi_way", longint'(bi_way), longint'(e_way));
      chk("R6", "bi_paddr", longint'(bi_paddr), longint'(e_line));
    end
    chk("R7", "wb_valid", longint'(wb_valid), longint'(e_wb));
    if (e_wb) chk("R7", "wb_paddr", longint'(wb_paddr), longint'(e_line));

    // first-level model follows the design's own back-invalidate
    if (bi_valid) begin
      fkey = int'(bi_set) * 2 + int'(bi_way);
      if (l1_line.exists(fkey) && l1_line[fkey] == bi_paddr) l1_line.delete(fkey);
    end
    fkey = (((vlo << 8) | ((pa >> 4) & 255)) * 2) + way;
    l1_line[fkey] = pa & ~32'hF;
    check_no_dup();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned a, b, c, pa;
    int vlo;
    rst_n = 1'b0; req_valid = 1'b0; req_paddr = '0; req_vpn_lo = '0; req_way = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in and just after reset
    chk("R1", "rsp_valid in reset", longint'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid after reset", longint'(rsp_valid), 0);
    chk("R1", "bi_valid after reset", longint'(bi_valid), 0);
    chk("R1", "wb_valid after reset", longint'(wb_valid), 0);

    a = 32'h0000_1230;
    b = a ^ 32'h0000_2000;   // same index, different tag
    c = a ^ 32'h0000_1000;   // same L1 set bits, different index

    issue(a, 0, 0, 0);       // R10: empty entry
    chk("R10", "no evict on empty fill", longint'(bi_valid), 0);
    chk("R1", "first request misses", longint'(rsp_hit), 0);
    issue(a, 2, 1, 1);       // R4: alias of a, old copy in set 0x023 way 0
    chk("R4", "alias bi_set", longint'(bi_set), 32'h023);
    issue(b, 2, 0, 0);       // R5/R7: conflict, dirty alias copy written back
    chk("R7", "dirty conflict writeback", longint'(wb_valid), 1);
    issue(c, 2, 0, 0);       // displaces b from L1 only
    issue(b, 2, 1, 1);       // R8/R9: L2 hit after L1 lost it
    chk("R8", "still resident after L1 loss", longint'(rsp_hit), 1);
    issue(b, 1, 0, 0);       // alias of b: way and dirty from the hit must be used
    chk("R9", "way recorded on hit", longint'(bi_way), 1);
    chk("R9", "dirty set on hit", longint'(wb_valid), 1);

    for (int i = 0; i < 3000; i++) begin
      pa  = (($urandom % 4) << 13) | (($urandom % 2) << 12) | (($urandom % 8) << 4) | ($urandom % 16);
      vlo = $urandom % 4;
      if (!l1_holds(pa, vlo)) issue(pa, vlo, $urandom % 2, 1'($urandom % 2));
    end

    @(negedge clk);
    chk("R2", "rsp_valid final idle", longint'(rsp_valid), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule